// File: doc/BRIEF.md
# Power-Up Strap Latch and Pin Handover Controller

This block governs a group of shared pins that carry configuration straps while power comes up and carry clocks afterwards. Once the power-on reset lets go, the pin drivers stay disabled for a fixed window. During that window the block copies every pin level into a configuration register on every cycle. On the last cycle of the window it keeps that copy for good. It then turns all drivers on while they drive low, and hands the pins to their clocks one at a time.

The controller is a four-state machine:
- `ST_SAMPLE`: drivers off, straps sampled on every cycle.
- `ST_HOLD`: drivers on, every pin forced low.
- `ST_RELEASE`: one more pin freed on each cycle.
- `ST_RUN`: all pins carry clocks.

Its transitions are:
- window expiry: `ST_SAMPLE` to `ST_HOLD`.
- hold expiry: `ST_HOLD` to `ST_RELEASE`.
- last pin freed: `ST_RELEASE` to `ST_RUN`.
- reset: any state to `ST_SAMPLE`.

The window length `WIN_CYCLES` is set in reference-clock cycles. A 2 ms window at 14.318 MHz needs about 28,636 cycles. The hold length is `HOLD_CYCLES`.

The low strap bits form the frequency-select word for the CPU and memory clock generators. The strap bit just above them picks the rate of the slow I/O controller clock. The downstream clock mux may cut the first clock pulse short when a pin is freed, and this is allowed.

Top module: `strap_handover_ctrl`

## Requirements
- R1: For the first `WIN_CYCLES` clock edges after reset is released, `pin_oe` is all zeros.
- R2: The configuration kept is the pin level present at the final edge of the window. Earlier levels are overwritten.
- R3: After the window ends, changes on `strap_in` do not affect `freq_sel` or `slow_io_24m` until the next reset.
- R4: At the edge that ends the window, all bits of `pin_oe` and `pin_hold_low` go to 1 together. All stay 1 for `HOLD_CYCLES` cycles.
- R5: After the hold, pins are freed in ascending index order, one pin per cycle. Pin 0 is freed on the first release cycle. Freed pins have `pin_hold_low` = 0, so at all times the still-held pins form a contiguous group at the top.
- R6: `freq_sel` equals the kept value of `strap_in[FSEL_W-1:0]`, bit for bit.
- R7: `slow_io_24m` equals the kept value of `strap_in[FSEL_W]`. A value of 1 selects 24 MHz and a value of 0 selects 48 MHz.
- R8: `cfg_done` goes high exactly one cycle after the edge that ends the window, and stays high until reset.
- R9: While reset is asserted, `pin_oe`, `pin_hold_low`, `freq_sel`, `slow_io_24m` and `cfg_done` are all 0. A reset in any state starts a full new window.
- R10: Once freed, a pin is not forced low again until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous assert |
| strap_in | input | NUM_PINS | Levels on the shared pins |
| pin_oe | output | NUM_PINS | Output driver enable per pin (1 = driving) |
| pin_hold_low | output | NUM_PINS | 1 = driven pin forced low, 0 = pin carries its clock |
| freq_sel | output | FSEL_W | Kept frequency-select word |
| slow_io_24m | output | 1 | Kept I/O-clock rate select (1 = 24 MHz, 0 = 48 MHz) |
| cfg_done | output | 1 | Configuration kept and handover started |

## Verification
The assertions assume that `rst_n` is released away from the active clock edge. They also assume the straps need no synchronizing, so whatever level is present at the final window edge is the level that counts.

The stimulus drives `rst_n` and `strap_in` only on the falling clock edge. It changes the straps right up to the last window cycle, and again after the window ends, to show which value is kept. It also applies reset both inside the window and after handover, so the checker's window counter is restarted from both states.

// File: rtl/shs_pkg.sv
package shs_pkg;
    typedef enum logic [1:0] {
        ST_SAMPLE  = 2'd0,
        ST_HOLD    = 2'd1,
        ST_RELEASE = 2'd2,
        ST_RUN     = 2'd3
    } shs_state_t;
endpackage

// File: rtl/shs_cycle_timer.sv
module shs_cycle_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic last
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT + 1) : 1;

    logic [CW-1:0] cnt;

    assign last = (cnt == CW'(LIMIT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (run && !last) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/shs_strap_latch.sv
module shs_strap_latch #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         capture,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q[b] <= 1'b0;
            end else if (capture) begin
                q[b] <= d[b];
            end
        end
    end
endmodule

// File: rtl/strap_handover_ctrl.sv
module strap_handover_ctrl
    import shs_pkg::*;
#(
    parameter int NUM_PINS    = 6,
    parameter int FSEL_W      = 5,
    parameter int WIN_CYCLES  = 28636,
    parameter int HOLD_CYCLES = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] strap_in,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic [NUM_PINS-1:0] pin_hold_low,
    output logic [FSEL_W-1:0]   freq_sel,
    output logic                slow_io_24m,
    output logic                cfg_done
);
    localparam int IW = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
    localparam logic [IW-1:0] LAST_IDX = IW'(NUM_PINS - 1);

    shs_state_t      state, nxt;
    logic [IW-1:0]   rel_idx;
    logic            done_q;
    logic            win_last, hold_last;
    logic [NUM_PINS-1:0] cfg_q;

    shs_cycle_timer #(.LIMIT(WIN_CYCLES)) u_win_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (1'b0),
        .run   (state == ST_SAMPLE),
        .last  (win_last)
    );

    shs_cycle_timer #(.LIMIT(HOLD_CYCLES)) u_hold_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state != ST_HOLD),
        .run   (state == ST_HOLD),
        .last  (hold_last)
    );

    shs_strap_latch #(.W(NUM_PINS)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (state == ST_SAMPLE),
        .d       (strap_in),
        .q       (cfg_q)
    );

    // State register, release pointer and completion flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_SAMPLE;
            rel_idx <= '0;
            done_q  <= 1'b0;
        end else begin
            state <= nxt;
            if (state != ST_SAMPLE) begin
                done_q <= 1'b1;
            end
            if (state == ST_RELEASE) begin
                if (rel_idx != LAST_IDX) begin
                    rel_idx <= rel_idx + 1'b1;
                end
            end else begin
                rel_idx <= '0;
            end
        end
    end

    // Next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_SAMPLE:  if (win_last)              nxt = ST_HOLD;
            ST_HOLD:    if (hold_last)             nxt = ST_RELEASE;
            ST_RELEASE: if (rel_idx == LAST_IDX)   nxt = ST_RUN;
            ST_RUN:                                nxt = ST_RUN;
        endcase
    end

    // Outputs
    always_comb begin
        pin_oe       = '0;
        pin_hold_low = '0;
        unique case (state)
            ST_SAMPLE: begin
                pin_oe       = '0;
                pin_hold_low = '0;
            end
            ST_HOLD: begin
                pin_oe       = '1;
                pin_hold_low = '1;
            end
            ST_RELEASE: begin
                pin_oe = '1;
                for (int i = 0; i < NUM_PINS; i++) begin
                    pin_hold_low[i] = (i > int'(rel_idx));
                end
            end
            ST_RUN: begin
                pin_oe       = '1;
                pin_hold_low = '0;
            end
        endcase
    end

    assign freq_sel    = cfg_q[FSEL_W-1:0];
    assign slow_io_24m = cfg_q[FSEL_W];
    assign cfg_done    = done_q;
endmodule

// File: rtl/shs_checker.sv
module shs_checker #(
    parameter int NUM_PINS   = 6,
    parameter int FSEL_W     = 5,
    parameter int WIN_CYCLES = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_PINS-1:0] pin_oe,
    input logic [NUM_PINS-1:0] pin_hold_low,
    input logic [FSEL_W-1:0]   freq_sel,
    input logic                slow_io_24m,
    input logic                cfg_done
);
    localparam int CW = $clog2(WIN_CYCLES + 1);

    logic [CW-1:0] since_rst;
    logic [NUM_PINS-1:0] freed_inv;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst <= '0;
        end else if (since_rst != CW'(WIN_CYCLES)) begin
            since_rst <= since_rst + 1'b1;
        end
    end

    assign freed_inv = ~pin_hold_low;

    assert_inputs_in_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst < CW'(WIN_CYCLES)) |-> (pin_oe == '0));

    assert_cfg_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |-> ($stable(freq_sel) && $stable(slow_io_24m)));

    assert_enable_all_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pin_oe[0]) |-> ((pin_oe == '1) && (pin_hold_low == '1)));

    assert_oe_uniform_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe == '0) || (pin_oe == '1));

    assert_release_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (freed_inv & (freed_inv + 1'b1)) == '0);

    assert_done_after_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pin_oe[0]) |=> $rose(cfg_done));

    assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |=> cfg_done);

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        assert_no_rehold_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (pin_oe[p] && !pin_hold_low[p]) |=> !pin_hold_low[p]);
    end
endmodule

bind strap_handover_ctrl shs_checker #(
    .NUM_PINS   (NUM_PINS),
    .FSEL_W     (FSEL_W),
    .WIN_CYCLES (WIN_CYCLES)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .pin_oe       (pin_oe),
    .pin_hold_low (pin_hold_low),
    .freq_sel     (freq_sel),
    .slow_io_24m  (slow_io_24m),
    .cfg_done     (cfg_done)
);

// File: tb/strap_handover_ctrl_tb_top.sv
module strap_handover_ctrl_tb_top;
    localparam int N    = 6;
    localparam int FW   = 5;
    localparam int WIN  = 20;
    localparam int HOLD = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] strap_in = '0;
    logic [N-1:0] pin_oe, pin_hold_low;
    logic [FW-1:0] freq_sel;
    logic         slow_io_24m, cfg_done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    strap_handover_ctrl #(
        .NUM_PINS(N), .FSEL_W(FW), .WIN_CYCLES(WIN), .HOLD_CYCLES(HOLD)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .strap_in(strap_in),
        .pin_oe(pin_oe), .pin_hold_low(pin_hold_low),
        .freq_sel(freq_sel), .slow_io_24m(slow_io_24m), .cfg_done(cfg_done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic hold_in_reset();
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R9 oe in reset", 32'(pin_oe), 0);
        chk("R9 hold in reset", 32'(pin_hold_low), 0);
        chk("R9 cfg in reset", {26'd0, slow_io_24m, freq_sel}, 0);
        chk("R9 done in reset", 32'(cfg_done), 0);
        step(2);
        rst_n = 1'b1;
    endtask

    // R1 R2 R4 R5 R6 R7 R8 R10 R3
    task automatic t_full_handover();
        hold_in_reset();
        strap_in = 6'h15;
        step(WIN - 1);
        chk("R1 oe low at last window cycle", 32'(pin_oe), 0);
        strap_in = 6'h2A;
        step(1);
        chk("R2 R6 freq_sel last value", 32'(freq_sel), 32'h0A);
        chk("R7 slow io 24MHz", 32'(slow_io_24m), 1);
        chk("R4 oe all on", 32'(pin_oe), 32'h3F);
        chk("R4 hold all low", 32'(pin_hold_low), 32'h3F);
        chk("R8 done not yet", 32'(cfg_done), 0);
        strap_in = 6'h00;
        step(1);
        chk("R8 done one cycle later", 32'(cfg_done), 1);
        chk("R3 freq_sel frozen", 32'(freq_sel), 32'h0A);
        step(HOLD - 2);
        chk("R4 still held at end of hold", 32'(pin_hold_low), 32'h3F);
        step(1);
        chk("R5 pin0 freed first", 32'(pin_hold_low), 32'h3E);
        for (int j = 1; j < N; j++) begin
            step(1);
            chk("R5 release order", 32'(pin_hold_low), 32'(6'h3F & ~((1 << (j + 1)) - 1)));
        end
        strap_in = 6'h3F;
        step(4);
        chk("R10 all stay freed", 32'(pin_hold_low), 0);
        chk("R3 cfg after late strap", {26'd0, slow_io_24m, freq_sel}, 32'h2A);
        chk("R8 done stays", 32'(cfg_done), 1);
        chk("R4 oe stays on", 32'(pin_oe), 32'h3F);
    endtask

    // R9 reset after handover, R7 48 MHz, R6 other pattern
    task automatic t_rerun_after_handover();
        hold_in_reset();
        strap_in = 6'h11;
        step(WIN - 1);
        chk("R9 R1 full window again", 32'(pin_oe), 0);
        step(1);
        chk("R9 oe on after new window", 32'(pin_oe), 32'h3F);
        chk("R6 freq_sel pattern 2", 32'(freq_sel), 32'h11);
        chk("R7 slow io 48MHz", 32'(slow_io_24m), 0);
    endtask

    // R9 reset inside the window restarts it
    task automatic t_reset_in_window();
        hold_in_reset();
        strap_in = 6'h33;
        step(7);
        hold_in_reset();
        step(WIN - 1);
        chk("R9 window restarted", 32'(pin_oe), 0);
        chk("R8 done low in window", 32'(cfg_done), 0);
        step(1);
        chk("R9 window ends after full count", 32'(pin_oe), 32'h3F);
        chk("R6 freq_sel after restart", 32'(freq_sel), 32'h13);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        t_full_handover();
        t_rerun_after_handover();
        t_reset_in_window();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule